// File: doc/BRIEF.md
# Preset Checking-Experiment Sequencer

This block runs a fixed fault-detection experiment against a six-state Mealy machine that sits outside it. After a one-cycle start request it drives one input symbol per clock into the machine under test and reads back the machine's output in the same clock. Each returned symbol is compared with the response that a fault-free machine would give. The block stops at the first disagreement and reports where it happened. If all 56 symbols match, it reports a pass.

The experiment is built into the block and has three phases, applied back to back with no idle cycles. The synchronising phase forces the machine into state B from any state. The permutation phase walks the machine around its cycle under input 2, eight times in a row. The cell phase is an Eulerian chain of forcing-plus-check cells: each cell is one forcing symbol followed by the two-symbol distinguishing sequence "22", and short runs of symbol 2 link one cell to the next.

The state of the run is always visible on the ports: busy, a one-cycle done pulse, pass or fail, the phase being applied, and a record of the index and phase of the first failing symbol. The machine under test is assumed to have no more than six states, and any fault in it is assumed to be present for the whole run.

Top module: `chkx_top`

## Requirements
- R1: While reset is high, and in the cycle after it falls, busy, done, pass, fail and the step strobe are 0, the phase is 0, and the fail index and fail phase are 0.
- R2: A start pulse seen while idle makes busy and the step strobe 1 and the phase 1 from the next cycle, with symbol index 0 on the symbol output. A start pulse seen while busy has no effect on the symbol stream or the phase.
- R3: Symbols are 2-bit values 0, 1 and 2. The stimulus stream, indices 0 to 55, is "10101", then "22222222", then "022 122 022 2 022 122 22 022 122 022 022 222 122 2 122 122", with no gaps.
- R4: Symbol k is on the symbol output, with the step strobe high, during the k-th cycle after the start edge. The response input is sampled at the clock edge that ends that cycle, and the machine under test consumes the symbol at that same edge. The step strobe is 1 exactly while busy.
- R5: The phase output uses 0 for idle, 1 for indices 0 to 4 (synchronising), 2 for indices 5 to 12 (permutation) and 3 for indices 13 to 55 (cells). Within a run the phase never decreases.
- R6: Responses in phase 1 are never compared. A run whose only wrong responses fall in indices 0 to 4 ends in a pass.
- R7: The expected response at index k ≥ 5 is the output of this machine, started in state B at index 5 and fed the stream from index 5 (notation state: input→next/output): A: 0→B/0 1→E/0 2→B/0; B: 0→F/1 1→E/0 2→C/2; C: 0→B/0 1→D/0 2→D/2; D: 0→B/0 1→A/1 2→F/1; E: 0→E/1 1→B/1 2→A/0; F: 0→C/1 1→B/0 2→E/2.
- R8: At the first compared mismatch, at index f, the block raises fail, records f and the phase of f, drops busy and the step strobe, and pulses done, all in the cycle after the edge that sampled index f. Index f+1 is never driven.
- R9: When all 56 symbols match, busy lasts 56 cycles, then pass rises together with a done pulse.
- R10: Done is high for exactly one cycle. Pass and fail are never 1 together. Pass, fail, the fail index and the fail phase hold while idle, and a new start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle run request |
| dut_resp_i | input | 2 | Output symbol of the machine under test |
| dut_sym_o | output | 2 | Registered input symbol for the machine under test |
| dut_step_o | output | 1 | The machine under test consumes dut_sym_o at the next edge |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| pass_o | output | 1 | The last run matched at every compared index |
| fail_o | output | 1 | The last run stopped on a mismatch |
| fail_idx_o | output | 6 | Index of the first mismatching symbol |
| fail_phase_o | output | 2 | Phase of the first mismatching symbol |
| phase_o | output | 2 | Phase currently being applied |

## Verification
The assertions check properties that must hold on every cycle. They cover entry into the synchronising phase on start, the phase staying 0 while idle and never going backwards during a run, the single-cycle done pulse, pass and fail never being high together, and the result registers holding while idle. Failures are never recorded in the synchronising phase, and a new fail always arrives together with done and the end of busy. Only the bench scenarios can show the rest. The driven symbol is checked against R3 at each index, and the run length and first failing index are checked against values computed from the machine table. These scenarios run against a model of the machine under test that starts in every one of its six states, with no fault, a transition fault, an output fault, and wrong responses confined to the synchronising phase.

// File: rtl/chkx_pkg.sv
package chkx_pkg;

  localparam int SYM_W    = 2;
  localparam int ST_W     = 3;
  localparam int SYNC_LEN = 5;
  localparam int PERM_LEN = 8;
  localparam int CELL_LEN = 43;
  localparam int SEQ_LEN  = SYNC_LEN + PERM_LEN + CELL_LEN;
  localparam int IDX_W    = $clog2(SEQ_LEN);

  localparam logic [SYM_W-1:0] PERM_SYM = 2'd2;
  localparam logic [ST_W-1:0]  SYNC_ST  = 3'd1;  // state B

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_PERM = 2'd2,
    PH_CELL = 2'd3
  } phase_e;

  // Specified machine: states A..F are 0..5.
  function automatic logic [ST_W-1:0] spec_next(input logic [ST_W-1:0] s,
                                                input logic [SYM_W-1:0] x);
    logic [ST_W-1:0] n;
    n = s;
    case ({s, x})
      {3'd0, 2'd0}: n = 3'd1;
      {3'd0, 2'd1}: n = 3'd4;
      {3'd0, 2'd2}: n = 3'd1;
      {3'd1, 2'd0}: n = 3'd5;
      {3'd1, 2'd1}: n = 3'd4;
      {3'd1, 2'd2}: n = 3'd2;
      {3'd2, 2'd0}: n = 3'd1;
      {3'd2, 2'd1}: n = 3'd3;
      {3'd2, 2'd2}: n = 3'd3;
      {3'd3, 2'd0}: n = 3'd1;
      {3'd3, 2'd1}: n = 3'd0;
      {3'd3, 2'd2}: n = 3'd5;
      {3'd4, 2'd0}: n = 3'd4;
      {3'd4, 2'd1}: n = 3'd1;
      {3'd4, 2'd2}: n = 3'd0;
      {3'd5, 2'd0}: n = 3'd2;
      {3'd5, 2'd1}: n = 3'd1;
      {3'd5, 2'd2}: n = 3'd4;
      default:      n = s;
    endcase
    return n;
  endfunction

  function automatic logic [SYM_W-1:0] spec_out(input logic [ST_W-1:0] s,
                                                input logic [SYM_W-1:0] x);
    logic [SYM_W-1:0] o;
    o = '0;
    case ({s, x})
      {3'd1, 2'd0}: o = 2'd1;
      {3'd1, 2'd2}: o = 2'd2;
      {3'd2, 2'd2}: o = 2'd2;
      {3'd3, 2'd1}: o = 2'd1;
      {3'd3, 2'd2}: o = 2'd1;
      {3'd4, 2'd0}: o = 2'd1;
      {3'd4, 2'd1}: o = 2'd1;
      {3'd5, 2'd0}: o = 2'd1;
      {3'd5, 2'd2}: o = 2'd2;
      default:      o = '0;
    endcase
    return o;
  endfunction

  // Stimulus symbol at a given index of the experiment.
  function automatic logic [SYM_W-1:0] seq_sym(input int i);
    int c;
    c = i - SYNC_LEN - PERM_LEN;
    if (i < SYNC_LEN) return ((i % 2) == 0) ? 2'd1 : 2'd0;
    if (c < 0) return PERM_SYM;
    case (c)
      0, 6, 10, 18, 24, 27:  return 2'd0;  // forcing symbol 0
      3, 13, 21, 33, 37, 40: return 2'd1;  // forcing symbol 1
      default:               return PERM_SYM;
    endcase
  endfunction

  // Fault-free response at a given index; zero during synchronisation.
  function automatic logic [SYM_W-1:0] seq_exp(input int i);
    logic [ST_W-1:0] s;
    s = SYNC_ST;
    if (i < SYNC_LEN) return '0;
    for (int j = SYNC_LEN; j < i; j++) s = spec_next(s, seq_sym(j));
    return spec_out(s, seq_sym(i));
  endfunction

  function automatic phase_e phase_of(input int i);
    if (i < SYNC_LEN) return PH_SYNC;
    if (i < SYNC_LEN + PERM_LEN) return PH_PERM;
    return PH_CELL;
  endfunction

endpackage

// File: rtl/chkx_rom.sv
module chkx_rom
  import chkx_pkg::*;
#(
  parameter int DEPTH  = SEQ_LEN,
  parameter int ADDR_W = IDX_W,
  parameter int DATA_W = SYM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] sym_o,
  output logic [DATA_W-1:0] exp_o
);

  localparam int WORD_W = 2 * DATA_W;

  logic [WORD_W-1:0] rom_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom_w[g] = {DATA_W'(seq_sym(g)), DATA_W'(seq_exp(g))};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_o <= '0;
      exp_o <= '0;
    end else begin
      {sym_o, exp_o} <= rom_w[addr_i];
    end
  end

endmodule

// File: rtl/chkx_ctrl.sv
module chkx_ctrl
  import chkx_pkg::*;
#(
  parameter int DEPTH  = SEQ_LEN,
  parameter int ADDR_W = IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output phase_e            phase_o
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] idx_q;
  logic              busy_q, done_q, pass_q;
  phase_e            phase_q;
  logic              end_w;

  assign end_w = busy_q && (stop_i || (idx_q == LAST));

  always_comb begin
    rd_addr_o = '0;
    if (busy_q && !end_w) rd_addr_o = idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      phase_q <= PH_IDLE;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          idx_q   <= '0;
          busy_q  <= 1'b1;
          pass_q  <= 1'b0;
          phase_q <= PH_SYNC;
        end
      end else if (end_w) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        pass_q  <= !stop_i;
        phase_q <= PH_IDLE;
      end else begin
        idx_q   <= idx_q + 1'b1;
        phase_q <= phase_of(int'(idx_q) + 1);
      end
    end
  end

  assign idx_o   = idx_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign pass_o  = pass_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/chkx_judge.sv
module chkx_judge
  import chkx_pkg::*;
#(
  parameter int ADDR_W = IDX_W,
  parameter int DATA_W = SYM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              busy_i,
  input  phase_e            phase_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [DATA_W-1:0] resp_i,
  input  logic [DATA_W-1:0] exp_i,
  output logic              mismatch_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_idx_o,
  output phase_e            fail_phase_o
);

  logic compare_en;

  assign compare_en = busy_i && ((phase_i == PH_PERM) || (phase_i == PH_CELL));
  assign mismatch_o = compare_en && (resp_i != exp_i);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      fail_o       <= 1'b0;
      fail_idx_o   <= '0;
      fail_phase_o <= PH_IDLE;
    end else if (mismatch_o) begin
      fail_o       <= 1'b1;
      fail_idx_o   <= idx_i;
      fail_phase_o <= phase_i;
    end
  end

endmodule

// File: rtl/chkx_top.sv
module chkx_top
  import chkx_pkg::*;
#(
  parameter int DEPTH  = SEQ_LEN,
  parameter int ADDR_W = IDX_W,
  parameter int DATA_W = SYM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] dut_resp_i,
  output logic [DATA_W-1:0] dut_sym_o,
  output logic              dut_step_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_idx_o,
  output logic [1:0]        fail_phase_o,
  output logic [1:0]        phase_o
);

  logic [ADDR_W-1:0] rd_addr, idx;
  logic [DATA_W-1:0] exp_sym;
  logic              busy, mismatch, clear;
  phase_e            phase, fail_phase;

  assign clear = start_i && !busy;

  chkx_rom #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .clk    (clk),
    .rst    (rst),
    .addr_i (rd_addr),
    .sym_o  (dut_sym_o),
    .exp_o  (exp_sym)
  );

  chkx_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .stop_i    (mismatch),
    .rd_addr_o (rd_addr),
    .idx_o     (idx),
    .busy_o    (busy),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .phase_o   (phase)
  );

  chkx_judge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_judge (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (clear),
    .busy_i       (busy),
    .phase_i      (phase),
    .idx_i        (idx),
    .resp_i       (dut_resp_i),
    .exp_i        (exp_sym),
    .mismatch_o   (mismatch),
    .fail_o       (fail_o),
    .fail_idx_o   (fail_idx_o),
    .fail_phase_o (fail_phase)
  );

  assign dut_step_o   = busy;
  assign busy_o       = busy;
  assign phase_o      = phase;
  assign fail_phase_o = fail_phase;

endmodule

// File: rtl/chkx_check.sv
module chkx_check #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              dut_step_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] fail_idx_o,
  input logic [1:0]        fail_phase_o,
  input logic [1:0]        phase_o
);

  assert_start_enters_sync_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && dut_step_o && phase_o == 2'd1));

  assert_idle_phase_R5: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (phase_o == 2'd0));

  assert_phase_order_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> (phase_o >= $past(phase_o)));

  assert_no_sync_fail_R6: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (fail_phase_o != 2'd1));

  assert_fail_stops_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> (!busy_o && !dut_step_o && done_o));

  assert_done_ends_run_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_verdict_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && fail_o));

  assert_verdict_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fail_o) && $stable(fail_idx_o)));

endmodule

bind chkx_top chkx_check #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .dut_step_o   (dut_step_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .fail_o       (fail_o),
  .fail_idx_o   (fail_idx_o),
  .fail_phase_o (fail_phase_o),
  .phase_o      (phase_o)
);

// File: tb/tb_chkx_top.sv
module tb_chkx_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_SYM      = 56;
  localparam int N_SYNC     = 5;
  localparam int N_PERM     = 8;
  localparam int WATCHDOG   = 100000;

  // Stimulus stream from R3, as ASCII digits, index 0 leftmost.
  localparam logic [8*N_SYM-1:0] STIM = {"10101", "22222222",
    "022", "122", "022", "2", "022", "122", "22", "022", "122",
    "022", "022", "222", "122", "2", "122", "122"};

  logic       clk = 1'b0;
  logic       rst, start;
  logic [1:0] dut_resp, dut_sym, fail_phase, phase;
  logic       dut_step, busy, done, pass, fail;
  logic [5:0] fail_idx;

  logic       m_load;
  logic [2:0] m_init, m_st;
  logic [1:0] fault;
  int         m_cnt;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chkx_top dut (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .dut_resp_i   (dut_resp),
    .dut_sym_o    (dut_sym),
    .dut_step_o   (dut_step),
    .busy_o       (busy),
    .done_o       (done),
    .pass_o       (pass),
    .fail_o       (fail),
    .fail_idx_o   (fail_idx),
    .fail_phase_o (fail_phase),
    .phase_o      (phase)
  );

  function automatic logic [1:0] stim_sym(input int i);
    logic [7:0] c;
    c = STIM[8*(N_SYM-1-i) +: 8];
    return 2'(c - 8'd48);
  endfunction

  function automatic int exp_phase(input int i);
    return (i < N_SYNC) ? 1 : (i < N_SYNC + N_PERM) ? 2 : 3;
  endfunction

  // Machine table from R7, indexed by input first.
  function automatic logic [2:0] m_next(input logic [2:0] s, input logic [1:0] x,
                                        input logic [1:0] flt);
    logic [2:0] n;
    case (x)
      2'd0: n = (s == 3'd1) ? 3'd5 : (s == 3'd4) ? 3'd4 : (s == 3'd5) ? 3'd2 : 3'd1;
      2'd1: n = (s == 3'd0 || s == 3'd1) ? 3'd4 : (s == 3'd2) ? 3'd3 :
                (s == 3'd3) ? 3'd0 : 3'd1;
      default: n = (s == 3'd0) ? 3'd1 : (s == 3'd1) ? 3'd2 : (s == 3'd2) ? 3'd3 :
                   (s == 3'd3) ? 3'd5 : (s == 3'd4) ? 3'd0 : 3'd4;
    endcase
    if (flt == 2'd1 && s == 3'd5 && x == 2'd0) n = 3'd1;   // transition fault
    return n;
  endfunction

  function automatic logic [1:0] m_out(input logic [2:0] s, input logic [1:0] x,
                                       input logic [1:0] flt, input int cnt);
    logic [1:0] o;
    case (x)
      2'd0: o = (s == 3'd1 || s == 3'd4 || s == 3'd5) ? 2'd1 : 2'd0;
      2'd1: o = (s == 3'd3 || s == 3'd4) ? 2'd1 : 2'd0;
      default: o = (s == 3'd1 || s == 3'd2 || s == 3'd5) ? 2'd2 :
                   (s == 3'd3) ? 2'd1 : 2'd0;
    endcase
    if (flt == 2'd2 && s == 3'd4 && x == 2'd1) o = 2'd0;  // output fault
    if (flt == 2'd3 && cnt < N_SYNC) o = o ^ 2'b01;       // wrong only while syncing
    return o;
  endfunction

  // First compared index where the faulty model differs from R7, or -1.
  function automatic int exp_fail(input int st, input int flt);
    logic [2:0] f, g;
    logic [1:0] x;
    f = 3'(st);
    g = 3'd1;
    for (int i = 0; i < N_SYM; i++) begin
      x = stim_sym(i);
      if (i == N_SYNC) g = 3'd1;
      if (i >= N_SYNC) begin
        if (m_out(f, x, 2'(flt), i) != m_out(g, x, 2'd0, i)) return i;
        g = m_next(g, x, 2'd0);
      end
      f = m_next(f, x, 2'(flt));
    end
    return -1;
  endfunction

  // Machine under test.
  always @(posedge clk) begin
    if (m_load) begin
      m_st  <= m_init;
      m_cnt <= 0;
    end else if (dut_step) begin
      m_st  <= m_next(m_st, dut_sym, fault);
      m_cnt <= m_cnt + 1;
    end
  end
  assign dut_resp = m_out(m_st, dut_sym, fault, m_cnt);

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic run(input int st, input int flt, input bit poke);
    int    ef, last, k;
    string vtag;
    ef   = exp_fail(st, flt);
    last = (ef < 0) ? N_SYM - 1 : ef;
    vtag = (flt == 0) ? "R9" : (flt == 3) ? "R6" : "R8";
    m_init = 3'(st);
    fault  = 2'(flt);
    m_load = 1'b1;
    @(negedge clk);
    m_load = 1'b0;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (busy && k < N_SYM + 4) begin
      check((k == 0) ? "R2" : "R3", int'(dut_sym), int'(stim_sym(k)));
      check("R5", int'(phase), exp_phase(k));
      check("R4", int'(dut_step), 1);
      check("R10", int'(done), 0);
      start = poke && (k == 10);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(vtag, k, last + 1);
    check(vtag, int'(done), 1);
    check("R4", int'(dut_step), 0);
    check(vtag, int'(pass), (ef < 0) ? 1 : 0);
    check(vtag, int'(fail), (ef < 0) ? 0 : 1);
    check("R7", int'(fail_idx), (ef < 0) ? 0 : ef);
    check("R8", int'(fail_phase), (ef < 0) ? 0 : exp_phase(ef));
    check("R5", int'(phase), 0);
    @(negedge clk);
    check("R10", int'(done), 0);
    check("R10", int'(pass), (ef < 0) ? 1 : 0);
    check("R10", int'(fail), (ef < 0) ? 0 : 1);
  endtask

  initial begin
    rst    = 1'b1;
    start  = 1'b0;
    m_load = 1'b1;
    m_init = 3'd0;
    fault  = 2'd0;
    repeat (3) @(negedge clk);
    rst    = 1'b0;
    m_load = 1'b0;
    @(negedge clk);
    check("R1", int'(busy), 0);
    check("R1", int'(done), 0);
    check("R1", int'(pass), 0);
    check("R1", int'(fail), 0);
    check("R1", int'(dut_step), 0);
    check("R1", int'(phase), 0);
    check("R1", int'(fail_idx), 0);
    check("R1", int'(fail_phase), 0);
    for (int flt = 0; flt < 4; flt++) begin
      for (int st = 0; st < 6; st++) begin
        run(st, flt, (flt == 0 && st == 0) || (flt == 1 && st == 3));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule